// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block decides when the core may leave reset after a power-on event, a brown-out event, an external reset pin, or a wake from sleep. A power-on or brown-out pulse starts a chain of up to two timed stages. The first is a power-up delay counted in ticks of a free-running slow timer. The second is an oscillator settling count of `OST_CYCLES` oscillator clocks.

Each stage runs only when the configuration calls for it. The power-up delay runs when its active-low enable is 0. The settling count runs only for the crystal/resonator oscillator class. A wake from sleep applies only the settling count, and only for crystal clocks.

Both stages are timed from the end of the power-on or brown-out pulse, not from the pin. If the pin is still held low when they expire, the core leaves reset as soon as the synchronised pin goes high. A small cause register records whether a power-on or a brown-out reset has happened since software last set its bits.

Top module: `pwrup_rst_seq`

## Requirements
- R1: When the power-up delay is enabled (`pwrt_en_ni`=0), the core is held in reset for exactly `PWRT_TICKS` cycles with `slow_tick_i` high, counted after the falling edge of a power-on pulse. For crystal class this is followed by exactly `OST_CYCLES` clocks. With the tick held high, the hold lasts PWRT_TICKS+OST_CYCLES clock cycles after the pulse ends.
- R2: The settling count runs only for `osc_class_i`=2'b00 (crystal/resonator). The classes 2'b01 (RC), 2'b10 (external clock) and 2'b11 (internal oscillator) skip it.
- R3: With `pwrt_en_ni`=1 the power-up delay is skipped. For a non-crystal class, reset is then released on the first clock edge after the pulse ends, with no time-out.
- R4: A brown-out pulse produces the same sequence as a power-on pulse for every class and enable setting.
- R5: A one-cycle `wake_req_i` while running holds the core in reset for `OST_CYCLES` clocks when the class is crystal. For any other class it has no effect on `core_rst_o`.
- R6: `pin_rst_ni` passes through a two-flop synchroniser. `core_rst_o` is high while the synchronised pin is low. A pin held low past the time-outs releases the core two clock edges after the pin rises. The pin neither starts nor restarts the time-outs.
- R7: A new power-on or brown-out pulse during any stage restarts the full sequence from the start of the power-up delay.
- R8: Cause bit 1 is cleared by a power-on pulse and left unchanged by brown-out, wake and pin resets. A software write stores `cause_wdata_i[1]` in it.
- R9: Cause bit 0 is cleared by a brown-out pulse and left unchanged by a power-on pulse, wake and pin resets. A software write stores `cause_wdata_i[0]` in it.
- R10: The bits of `cause_o` above bit 1 always read 0. A power-on or brown-out pulse in the same cycle as a software write takes precedence for the bit it clears.
- R11: The power-up delay advances only on cycles where `slow_tick_i` is high. While the tick stays low the core stays in reset.
- R12: While `rst_ni` is low, `core_rst_o` is 1 and `cause_o` is 0. After `rst_ni` is released, the block runs the power-on sequence as if a pulse had just ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low register reset, released synchronously |
| por_pulse_i | input | 1 | Power-on detector pulse, active high |
| bor_pulse_i | input | 1 | Brown-out detector pulse, active high |
| pin_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| wake_req_i | input | 1 | One-cycle wake-from-sleep request |
| slow_tick_i | input | 1 | Enable tick from the free-running slow timer |
| osc_class_i | input | 2 | Oscillator class: 00 crystal, 01 RC, 10 external, 11 internal |
| pwrt_en_ni | input | 1 | Power-up delay enable, active low |
| cause_we_i | input | 1 | Software write strobe for the cause register |
| cause_wdata_i | input | 2 | Software write data for cause bits 1:0 |
| cause_o | output | CAUSE_W | Reset-cause register, bits above 1 read 0 |
| core_rst_o | output | 1 | Reset to the core, active high |

## Verification
If the sequencer state goes wrong, `core_rst_o` falls too early or too late. This shows as a hold length that differs from the arithmetic sum of the enabled stages, visible within one stage length of the pulse. The bench measures that length for every class, enable setting and trigger kind. A corrupted stage counter shows as a hold that is off by whole cycles, and a stuck stage shows as a reset that never releases before the run watchdog.

If the cause register takes a wrong update, the error is visible at `cause_o` on the clock after the offending pulse or write. The bench reads the register after each kind of event.

// File: rtl/pwrup_rst_pkg.sv
package pwrup_rst_pkg;

  typedef enum logic [1:0] {
    OSC_XTAL = 2'b00,
    OSC_RC   = 2'b01,
    OSC_EXT  = 2'b10,
    OSC_INT  = 2'b11
  } osc_class_e;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_RUN  = 3'd3
  } seq_state_e;

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];

  // A low pin level is seen at the output two edges later (R6)
  assert_pin_low_reaches_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_i |-> ##2 !sync_o);

endmodule

// File: rtl/rst_stage_timer.sv
module rst_stage_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic step_i,
  output logic done_o
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    cnt_en  = !active_i || step_i;
    cnt_d   = cnt_q;
    if (!active_i)    cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
    done_o  = active_i && step_i && at_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Counter never passes its terminal value (R1)
  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // Without a step the count holds (R11)
  assert_no_step_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !step_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int CAUSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_i,
  input  logic               bor_i,
  input  logic               we_i,
  input  logic [1:0]         wdata_i,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam int PAD_W = CAUSE_W - 2;

  logic [1:0] bits_q;
  logic [1:0] bits_d;
  logic       upd_en;

  always_comb begin
    upd_en = por_i || bor_i || we_i;
    bits_d = bits_q;
    if (we_i) bits_d = wdata_i;
    if (por_i) bits_d[1] = 1'b0;
    if (bor_i) bits_d[0] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bits_q <= '0;
    else if (upd_en) bits_q <= bits_d;
  end

  assign cause_o = {{PAD_W{1'b0}}, bits_q};

  assert_por_clears_bit1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> !cause_o[1]);

  assert_bor_clears_bit0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bor_i |=> !cause_o[0]);

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && !bor_i && !we_i) |=> $stable(cause_o));

  assert_por_keeps_bit0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i && !bor_i && !we_i) |=> (cause_o[0] == $past(cause_o[0])));

endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import pwrup_rst_pkg::*;
#(
  parameter int PWRT_TICKS = 8,
  parameter int OST_CYCLES = 1024,
  parameter int CAUSE_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_pulse_i,
  input  logic               bor_pulse_i,
  input  logic               pin_rst_ni,
  input  logic               wake_req_i,
  input  logic               slow_tick_i,
  input  logic [1:0]         osc_class_i,
  input  logic               pwrt_en_ni,
  input  logic               cause_we_i,
  input  logic [1:0]         cause_wdata_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               core_rst_o
);

  seq_state_e state_q;
  seq_state_e state_d;
  osc_class_e osc_class;
  logic       is_xtal;
  logic       pwrt_on;
  logic       restart;
  logic       pwrt_done;
  logic       ost_done;
  logic       pin_sync;

  assign osc_class = osc_class_e'(osc_class_i);
  assign is_xtal   = (osc_class == OSC_XTAL);
  assign pwrt_on   = !pwrt_en_ni;
  assign restart   = por_pulse_i || bor_pulse_i;

  rst_pin_sync #(.STAGES(2)) pin_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_rst_ni),
    .sync_o (pin_sync)
  );

  rst_stage_timer #(.LIMIT(PWRT_TICKS)) pwrt_tmr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (state_q == ST_PWRT),
    .step_i   (slow_tick_i),
    .done_o   (pwrt_done)
  );

  rst_stage_timer #(.LIMIT(OST_CYCLES)) ost_tmr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (state_q == ST_OST),
    .step_i   (1'b1),
    .done_o   (ost_done)
  );

  rst_cause_reg #(.CAUSE_W(CAUSE_W)) cause_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .por_i   (por_pulse_i),
    .bor_i   (bor_pulse_i),
    .we_i    (cause_we_i),
    .wdata_i (cause_wdata_i),
    .cause_o (cause_o)
  );

  always_comb begin
    state_d = state_q;
    if (restart) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (pwrt_on)      state_d = ST_PWRT;
          else if (is_xtal) state_d = ST_OST;
          else              state_d = ST_RUN;
        end
        ST_PWRT: if (pwrt_done) state_d = is_xtal ? ST_OST : ST_RUN;
        ST_OST:  if (ost_done)  state_d = ST_RUN;
        ST_RUN:  if (wake_req_i && is_xtal) state_d = ST_OST;
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HOLD;
    else         state_q <= state_d;
  end

  assign core_rst_o = (state_q != ST_RUN) || !pin_sync;

  assert_pulse_holds_core_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> core_rst_o);

  assert_ost_only_xtal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OST) |-> is_xtal);

  assert_wake_nonxtal_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && wake_req_i && !is_xtal && !restart) |=> (state_q == ST_RUN));

  assert_pwrt_skipped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PWRT) |-> pwrt_on);

endmodule

// File: tb/pwrup_rst_seq_tb.sv
module pwrup_rst_seq_tb_top;

  localparam int N = 8;
  localparam int M = 1024;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       por, bor, pin_n, wake, tick;
  logic [1:0] cls;
  logic       pwrt_en_n;
  logic       we;
  logic [1:0] wdata;
  logic [7:0] cause;
  logic       core_rst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwrup_rst_seq #(.PWRT_TICKS(N), .OST_CYCLES(M), .CAUSE_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .por_pulse_i(por), .bor_pulse_i(bor),
    .pin_rst_ni(pin_n), .wake_req_i(wake), .slow_tick_i(tick),
    .osc_class_i(cls), .pwrt_en_ni(pwrt_en_n), .cause_we_i(we),
    .cause_wdata_i(wdata), .cause_o(cause), .core_rst_o(core_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_hold(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (!core_rst || n > 5000) break;
      n++;
    end
  endtask

  // kind: 0 power-on, 1 brown-out, 2 wake
  task automatic pulse(input int kind);
    @(negedge clk);
    if (kind == 0) por = 1'b1;
    else if (kind == 1) bor = 1'b1;
    else wake = 1'b1;
    @(negedge clk);
    por = 1'b0; bor = 1'b0; wake = 1'b0;
  endtask

  task automatic write_cause(input logic [1:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_ni = 1'b0; por = 0; bor = 0; pin_n = 1; wake = 0; tick = 1;
    cls = 2'b00; pwrt_en_n = 1'b0; we = 0; wdata = 2'b00;
    repeat (3) @(negedge clk);
    chk("R12 core_rst in reset", int'(core_rst), 1);
    chk("R12 cause in reset", int'(cause), 0);
    rst_ni = 1'b1;
    count_hold(n);
    chk("R12 sequence after reset release", n, N + M);

    // R1 R2 R3 R4: sweep class x enable x trigger
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 4; c++) begin
        for (int e = 0; e < 2; e++) begin
          int exp;
          cls = 2'(c); pwrt_en_n = 1'(e);
          pulse(k);
          count_hold(n);
          exp = ((e == 0) ? N : 0) + ((c == 0) ? M : 0);
          if (k == 0) chk("R1 R2 R3 power-on hold length", n, exp);
          else        chk("R4 brown-out hold length", n, exp);
        end
      end
    end

    // R5: wake holds only in crystal class
    pwrt_en_n = 1'b0;
    for (int c = 0; c < 4; c++) begin
      cls = 2'(c);
      pulse(0);
      count_hold(n);
      pulse(2);
      count_hold(n);
      chk("R5 wake hold length", n, (c == 0) ? (M - 1) : 0);
    end

    // R11: no tick, no progress
    cls = 2'b00;
    @(negedge clk); tick = 1'b0;
    pulse(0);
    repeat (60) @(negedge clk);
    chk("R11 held without tick", int'(core_rst), 1);
    tick = 1'b1;
    count_hold(n);
    chk("R11 hold after tick resumes", n, N + M - 1);

    // R7: restart during a stage
    pulse(0);
    repeat (N + 5) @(negedge clk);
    chk("R7 mid-stage in reset", int'(core_rst), 1);
    pulse(1);
    count_hold(n);
    chk("R7 restart full length", n, N + M);

    // R6: long pin hold absorbs the time-outs
    @(negedge clk); pin_n = 1'b0;
    pulse(0);
    repeat (N + M + 20) @(negedge clk);
    chk("R6 held by pin after timeouts", int'(core_rst), 1);
    pin_n = 1'b1;
    count_hold(n);
    chk("R6 release after pin rises", n, 1);

    // R6: pin during run asserts reset, no restart
    @(negedge clk); pin_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 pin asserts core reset", int'(core_rst), 1);
    pin_n = 1'b1;
    count_hold(n);
    chk("R6 pin release no timers", n, 1);

    // R8 R9 R10: cause register
    write_cause(2'b11);
    chk("R10 write and upper bits zero", int'(cause), 3);
    pulse(1);
    chk("R9 brown-out clears bit0 only", int'(cause), 2);
    count_hold(n);
    write_cause(2'b11);
    pulse(0);
    chk("R8 power-on clears bit1 only", int'(cause), 1);
    count_hold(n);
    write_cause(2'b11);
    pulse(2);
    count_hold(n);
    @(negedge clk); pin_n = 1'b0;
    repeat (3) @(negedge clk);
    pin_n = 1'b1;
    count_hold(n);
    chk("R8 R9 wake and pin leave cause", int'(cause), 3);
    @(negedge clk);
    we = 1'b1; wdata = 2'b11; por = 1'b1;
    @(negedge clk);
    we = 1'b0; por = 1'b0;
    chk("R10 pulse beats write", int'(cause), 1);
    count_hold(n);
    write_cause(2'b10);
    chk("R8 write sets bit1", int'(cause), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule